// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block sits on the reader side of a contactless link and receives a tag response of fixed length. The response carries no start marker, stop marker or length field. The reader therefore tells the block how many bits to expect, and the block measures time from a reference point: the end of the reader's own frame. After a fixed wait, the block opens one time window per bit. In each window it counts the level changes on the hysteresis-filtered subcarrier input. A count inside a fixed band means subcarrier was present, and the bit is a 1. Any other count is a 0.

A tag that sends only zeros produces the same input as no tag at all, so the length can never be taken from the signal. The controller loads a precomputed keystream word when it signals the end of its frame. Each detected 1 flips the matching keystream bit, so the word that comes out is already decrypted. When reception ends, the block pulses a done strobe. It also restarts its reference tick counter, which the controller uses to time its next frame.

Top module: `sc_edge_bit_rx`

## Requirements
- R1: After reset, `busy`, `done`, `data_out`, `bits_out` and `tick_count` are all zero.
- R2: The first bit window opens 490 ticks after an accepted `frame_end`. Subcarrier edges that arrive before it opens are not counted.
- R3: Bit windows are 150 ticks long and follow each other with no gap. For a clamped request of n bits and one clock per tick, `done` is high in the clock cycle registered 490 + 150·n clock edges after the edge that samples `frame_end`.
- R4: A window whose edge count is greater than 20 and less than 60 gives a 1. Counts of 20 or less, and counts of 60 or more, give a 0.
- R5: The per-window edge counter saturates at 63. Any count above 63 therefore gives a 0 and never wraps back into the accepted band.
- R6: Rising and falling transitions of `sc_in` each count as one edge, after a two-stage synchronizer.
- R7: A request above 32 bits is clamped to 32 bits. A request of 0 bits ends at the first window opening with `bits_out` = 0 and `data_out` = keystream.
- R8: Bit i of the response is received in window i, least significant bit first. `data_out` equals `key_in` with bit i inverted for every window i that decided 1.
- R9: `done` is high for exactly one cycle. `data_out` and `bits_out` then hold their values until the next accepted `frame_end`.
- R10: `tick_count` becomes 0 on an accepted `frame_end` and again in the cycle `done` is high. Otherwise it rises by one per tick and saturates at its maximum.
- R11: A `frame_end` that arrives while `busy` is high is ignored. It does not change the timing or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_end | input | 1 | One-cycle pulse: the reader frame has ended, start reception |
| bit_req | input | 6 | Number of response bits to receive (clamped to 32) |
| key_in | input | 32 | Keystream word, sampled with an accepted `frame_end` |
| sc_in | input | 1 | Asynchronous hysteresis-filtered subcarrier level |
| busy | output | 1 | Reception in progress |
| done | output | 1 | One-cycle strobe: `data_out` and `bits_out` are final |
| data_out | output | 32 | Decrypted response, LSB received first |
| bits_out | output | 6 | Number of bits received |
| tick_count | output | 13 | Ticks since the last reference point, saturating |

## Verification
Assertions check on every cycle that `done` is a single-cycle pulse and that it coincides with a restarted `tick_count` and a bit count of at most 32. They also check that a `frame_end` during reception keeps the block busy, that results stay stable while idle, and that the edge counter holds at 63. Only the bench scenarios can show the exact cycle at which each window opens and closes. The same goes for the threshold band at 20/21 and 59/60, for saturation above 63, for the LSB-first keystream inversion, and for stray edges during the wait being ignored. The bench drives known edge counts into the middle of each window and compares against words computed from the requirements.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_WAIT = 2'd1,
    RX_BITS = 2'd2
  } rx_state_e;

  // Clamp a requested bit count to the largest supported frame.
  function automatic int unsigned clamp_req(input int unsigned req, input int unsigned max_bits);
    return (req > max_bits) ? max_bits : req;
  endfunction

endpackage

// File: rtl/sc_rx_tick.sv
module sc_rx_tick #(
  parameter int unsigned TICK_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    if (restart || pre_q == PRE_LAST) pre_d = '0;
    else                              pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = (pre_q == PRE_LAST);

endmodule

// File: rtl/sc_rx_edge_det.sv
module sc_rx_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sc_in,
  output logic edge_seen
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= sc_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  // Either direction of change is one edge.
  assign edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;

endmodule

// File: rtl/sc_rx_win_cnt.sv
module sc_rx_win_cnt #(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned LO_THR = 20,
  parameter int unsigned HI_THR = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic edge_seen,
  input  logic win_close,
  output logic bit_one
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  always_comb begin
    cnt_inc = cnt_q;
    if (count_en && edge_seen && cnt_q != CNT_MAX) cnt_inc = cnt_q + CNT_W'(1);
  end

  always_comb begin
    if (win_close)     cnt_d = '0;
    else if (count_en) cnt_d = cnt_inc;
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_one = (32'(cnt_inc) > LO_THR) && (32'(cnt_inc) < HI_THR);

  AST_EDGE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !win_close && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R5

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/sc_edge_bit_rx.sv
module sc_edge_bit_rx
  import sc_rx_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 1,
  parameter int unsigned FIRST_OFS   = 490,
  parameter int unsigned WIN_LEN     = 150,
  parameter int unsigned LO_THR      = 20,
  parameter int unsigned HI_THR      = 60,
  parameter int unsigned CNT_W       = 6,
  parameter int unsigned MAX_BITS    = 32,
  parameter int unsigned REQ_W       = 6,
  parameter int unsigned REF_W       = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_end,
  input  logic [REQ_W-1:0]             bit_req,
  input  logic [MAX_BITS-1:0]          key_in,
  input  logic                         sc_in,
  output logic                         busy,
  output logic                         done,
  output logic [MAX_BITS-1:0]          data_out,
  output logic [$clog2(MAX_BITS+1)-1:0] bits_out,
  output logic [REF_W-1:0]             tick_count
);
  localparam int unsigned IDX_W = $clog2(MAX_BITS + 1);
  localparam int unsigned WIN_W = $clog2(WIN_LEN);
  localparam logic [REF_W-1:0] REF_MAX  = {REF_W{1'b1}};
  localparam logic [REF_W-1:0] OFS_LAST = REF_W'(FIRST_OFS - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

  rx_state_e            state_q, state_d;
  logic [REF_W-1:0]     tcnt_q, tcnt_d;
  logic [WIN_W-1:0]     wcnt_q, wcnt_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [IDX_W-1:0]     nbits_q, nbits_d;
  logic [IDX_W-1:0]     bits_q, bits_d;
  logic [MAX_BITS-1:0]  data_q, data_d;
  logic                 done_q, done_d;

  logic tick, edge_seen, bit_one, win_close, finish, accept, count_en;

  sc_rx_tick #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept || finish), .tick(tick)
  );

  sc_rx_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk(clk), .rst_n(rst_n), .sc_in(sc_in), .edge_seen(edge_seen)
  );

  sc_rx_win_cnt #(.CNT_W(CNT_W), .LO_THR(LO_THR), .HI_THR(HI_THR)) i_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .edge_seen(edge_seen),
    .win_close(win_close), .bit_one(bit_one)
  );

  assign accept   = frame_end && (state_q == RX_IDLE);
  assign count_en = (state_q == RX_BITS);

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    wcnt_d    = wcnt_q;
    idx_d     = idx_q;
    nbits_d   = nbits_q;
    bits_d    = bits_q;
    data_d    = data_q;
    win_close = 1'b0;
    finish    = 1'b0;

    unique case (state_q)
      RX_IDLE: begin
        if (frame_end) begin
          state_d = RX_WAIT;
          data_d  = key_in;
          nbits_d = IDX_W'(clamp_req(32'(bit_req), MAX_BITS));
          idx_d   = '0;
          wcnt_d  = '0;
        end
      end
      RX_WAIT: begin
        if (tick && tcnt_q == OFS_LAST) begin
          if (nbits_q == '0) finish = 1'b1;
          else begin
            state_d = RX_BITS;
            wcnt_d  = '0;
          end
        end
      end
      RX_BITS: begin
        if (tick) begin
          if (wcnt_q == WIN_LAST) begin
            win_close = 1'b1;
            wcnt_d    = '0;
            if (bit_one) data_d = data_q ^ (MAX_BITS'(1) << idx_q);
            if (idx_q == nbits_q - IDX_W'(1)) finish = 1'b1;
            else                              idx_d  = idx_q + IDX_W'(1);
          end else begin
            wcnt_d = wcnt_q + WIN_W'(1);
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase

    if (finish) begin
      state_d = RX_IDLE;
      bits_d  = nbits_q;
    end
    done_d = finish;

    if (accept || finish)               tcnt_d = '0;
    else if (tick && tcnt_q != REF_MAX) tcnt_d = tcnt_q + REF_W'(1);
    else                                tcnt_d = tcnt_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      tcnt_q  <= '0;
      wcnt_q  <= '0;
      idx_q   <= '0;
      nbits_q <= '0;
      bits_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      wcnt_q  <= wcnt_d;
      idx_q   <= idx_d;
      nbits_q <= nbits_d;
      bits_q  <= bits_d;
      data_q  <= data_d;
      done_q  <= done_d;
    end
  end

  assign busy       = (state_q != RX_IDLE);
  assign done       = done_q;
  assign data_out   = data_q;
  assign bits_out   = bits_q;
  assign tick_count = tcnt_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_BITS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(bits_out) <= MAX_BITS)); // R7

  AST_REF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tick_count == '0 && !busy)); // R10

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_end) |=> (busy || done)); // R11

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !frame_end) |=> ($stable(data_out) && $stable(bits_out))); // R9

endmodule

// File: tb/test_sc_edge_bit_rx.sv
module test_sc_edge_bit_rx;

  localparam int OFS = 490;
  localparam int WIN = 150;

  logic        clk;
  logic        rst_n;
  logic        frame_end;
  logic [5:0]  bit_req;
  logic [31:0] key_in;
  logic        sc_in;
  logic        busy, done;
  logic [31:0] data_out;
  logic [5:0]  bits_out;
  logic [12:0] tick_count;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  int cnt_tab [32];

  sc_edge_bit_rx i_sc_edge_bit_rx (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .bit_req(bit_req),
    .key_in(key_in), .sc_in(sc_in), .busy(busy), .done(done),
    .data_out(data_out), .bits_out(bits_out), .tick_count(tick_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cycles);
        summary();
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int n, input logic [31:0] key);
    logic [31:0] w = key;
    for (int i = 0; i < n; i++)
      if (cnt_tab[i] > 20 && cnt_tab[i] < 60) w[i] = ~w[i];
    return w;
  endfunction

  // One reception: edge counts come from cnt_tab.
  task automatic run_frame(input int req, input logic [31:0] key,
                           input bit stray, input bit mid_fe, input string tag);
    int n = (req > 32) ? 32 : req;
    int last = OFS + WIN * n;
    logic [31:0] exp = exp_word(n, key);
    bit early = 0;
    @(negedge clk);
    frame_end = 1'b1;
    bit_req   = 6'(req);
    key_in    = key;
    @(negedge clk);
    frame_end = 1'b0;
    key_in    = ~key;
    chk(busy === 1'b1 && tick_count === 13'd0, {"R10 start ", tag}, tick_count, 0);
    for (int j = 1; j <= last; j++) begin
      @(negedge clk);
      frame_end = 1'b0;
      if (j < last && done) early = 1;
      if (j == last) begin
        chk(!early && done === 1'b1, {"R3 done timing ", tag}, done, 1);
        chk(data_out === exp, {"R8 data ", tag}, data_out, exp);
        chk(bits_out === 6'(n), {"R7 bit count ", tag}, bits_out, n);
        chk(tick_count === 13'd0 && busy === 1'b0, {"R10 restart ", tag}, tick_count, 0);
      end else begin
        if (stray && j >= 100 && j < 160 && (j % 2) == 0) sc_in = ~sc_in;
        if (mid_fe && j == 700) frame_end = 1'b1;
        if (j > OFS) begin
          int rel = j - OFS;
          int wi  = rel / WIN;
          int off = rel % WIN;
          if (wi < n && off >= 6 && ((off - 6) % 2) == 0 && ((off - 6) / 2) < cnt_tab[wi])
            sc_in = ~sc_in;
        end
      end
    end
    repeat (5) @(negedge clk);
    chk(tick_count === 13'd5, {"R10 count after ", tag}, tick_count, 5);
    chk(data_out === exp && done === 1'b0, {"R9 hold ", tag}, data_out, exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n     = 1'b0;
    frame_end = 1'b0;
    bit_req   = '0;
    key_in    = '0;
    sc_in     = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && data_out === 32'd0 && bits_out === 6'd0
        && tick_count === 13'd0, "R1 reset state", data_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Threshold and saturation corners: R4, R5, R6
    cnt_tab[0] = 20; cnt_tab[1] = 21; cnt_tab[2] = 59; cnt_tab[3] = 60;
    cnt_tab[4] = 63; cnt_tab[5] = 69; cnt_tab[6] = 42; cnt_tab[7] = 0;
    run_frame(8, 32'hA5A5_0F0F, 1'b0, 1'b0, "R4 R5 thresholds");

    // Zero-bit request: R7
    run_frame(0, 32'h1234_5678, 1'b0, 1'b0, "R7 zero bits");

    // Stray edges in the wait and a frame_end while busy: R2, R11
    for (int i = 0; i < 32; i++) cnt_tab[i] = (i % 3 == 0) ? 42 : 3;
    run_frame(5, 32'h0000_0000, 1'b1, 1'b1, "R2 R11 stray and ignored");

    // Over-long request clamped, full-width LSB-first word: R7, R8, R3
    for (int i = 0; i < 32; i++) cnt_tab[i] = (i % 2 == 0) ? 40 : (i % 5) * 5;
    run_frame(40, 32'hFFFF_0000, 1'b0, 1'b0, "R7 R8 clamp 32");

    // Constrained random frames: R4, R8
    for (int f = 0; f < 6; f++) begin
      int n = 1 + int'($urandom_range(7));
      for (int i = 0; i < 32; i++) begin
        case ($urandom_range(3))
          0: cnt_tab[i] = int'($urandom_range(20));
          1: cnt_tab[i] = 21 + int'($urandom_range(38));
          2: cnt_tab[i] = 60 + int'($urandom_range(9));
          default: cnt_tab[i] = 18 + int'($urandom_range(45));
        endcase
      end
      run_frame(n, $urandom, 1'b0, 1'b0, "R4 R8 random");
    end

    summary();
  end

endmodule